// File: doc/BRIEF.md
# Bytecode Operand Field Decoder

This block sits behind the opcode lookup of a compact bytecode engine with 64-bit registers. Given the operand-layout category of the current instruction, its operand byte count (skip length), its program counter and a twelve-byte window of the code that follows the opcode byte, it extracts up to three register indices, two sign-extended immediates and one PC-relative branch target. Part of the window may lie past the end of the code image. An availability count says how many leading window bytes are real, and every byte after that reads as zero.

Immediate lengths come from nibbles of the operand bytes or from the skip length, and are never longer than four bytes. Register indices are limited to the thirteen architectural registers. The decode itself is combinational. All results are captured in one output register stage, with a valid pulse one clock after the input strobe.

Top module: `arg_decoder`

## Requirements
- R1: Results appear on the clock edge after `inValid` is sampled high, with `outValid` high for exactly that one cycle. Without `inValid`, all result outputs hold their values. Reset clears every output to zero.
- R2: Window byte k (bits 8k+7:8k) is the code byte at pc+1+k. Byte k reads as 0x00 whenever k >= `availBytes`.
- R3: A field of n bytes (n in 0..4) is assembled little-endian and sign-extended from bit 8n-1 to 64 bits. A zero-length field yields 0.
- R4: A register index taken from a nibble is clamped: 13, 14 and 15 become 12.
- R5: In category 8 (two registers), the low nibble of byte 0 gives `rd` and the high nibble gives `ra`. In categories 9 to 12, the low nibble gives `ra` and the high nibble gives `rb`. Categories 2, 5, 6 and 7 take `ra` from the low nibble.
- R6: In category 12 (three registers), `rd` is the whole of window byte 1 clamped to 12.
- R7: Category 1 (one immediate) and category 4 (one jump) read min(skip,4) bytes from byte 0. For category 4, `offset` = pc + value, modulo 2^64.
- R8: Category 2 (register plus wide constant) places bytes 1..8 in `immX` as an unsigned little-endian value.
- R9: Category 3 (two immediates): lx = min(byte0 mod 8, 4), and ly = min(skip-lx-1, 4) if skip > lx+1, else 0. `immX` starts at byte 1 and `immY` at byte 1+lx.
- R10: Categories 6 and 7 take lx = min(byte0[6:4], 4), use the ly rule of R9, and start `immX` at byte 1. In category 7 the second field is sent to `offset` as pc + value instead of to `immY`.
- R11: Category 11: lx = min(byte1 mod 8, 4), and ly = min(skip-lx-2, 4) if skip > lx+2, else 0. The fields start at byte 2 and byte 2+lx.
- R12: Categories 5, 9 and 10 read min(skip-1, 4) bytes from byte 1 when skip > 1, otherwise zero bytes. Category 10 sends the value to `offset` as pc + value, and categories 5 and 9 send it to `immX`.
- R13: Every output field that a category does not use is zero. Categories 0, 13, 14 and 15 produce all-zero fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Decode request for the current inputs |
| category | input | 4 | Operand-layout category code |
| skipLen | input | SKIP_W (8) | Operand byte count of the instruction |
| pc | input | XLEN (64) | Address of the opcode byte |
| window | input | 8*WIN_BYTES (96) | Code bytes from pc+1 upward, byte 0 in the low bits |
| availBytes | input | AVAIL_W (4) | Number of window bytes inside the code image |
| outValid | output | 1 | One-cycle result strobe |
| ra | output | 4 | First register index |
| rb | output | 4 | Second register index |
| rd | output | 4 | Destination register index |
| immX | output | XLEN (64) | First immediate, or the wide constant |
| immY | output | XLEN (64) | Second immediate |
| offset | output | XLEN (64) | PC-relative branch target |

## Verification
A wrong length or start code from the control logic shows up in the very next output cycle: an immediate with the wrong sign, the wrong byte order or stray high bytes, or a second field shifted by whole bytes. Wrong masking or register clamping is equally immediate, seen as nonzero data from bytes that should be absent or as an index above 12. Each vector is checked one cycle after its strobe. Hold cycles confirm that stale inputs do not leak into held results.

// File: rtl/argdec_pkg.sv
package argdec_pkg;
  localparam int MAX_FIELD = 4;
  localparam int REG_TOP   = 12;

  typedef enum logic [3:0] {
    CAT_NONE         = 4'd0,
    CAT_IMM          = 4'd1,
    CAT_REG_WIDE     = 4'd2,
    CAT_IMM2         = 4'd3,
    CAT_JUMP         = 4'd4,
    CAT_REG_IMM      = 4'd5,
    CAT_REG_IMM2     = 4'd6,
    CAT_REG_IMM_JUMP = 4'd7,
    CAT_REG2         = 4'd8,
    CAT_REG2_IMM     = 4'd9,
    CAT_REG2_JUMP    = 4'd10,
    CAT_REG2_IMM2    = 4'd11,
    CAT_REG3         = 4'd12
  } cat_e;

  typedef enum logic [1:0] {
    SEL_ZERO = 2'd0,
    SEL_LO   = 2'd1,
    SEL_HI   = 2'd2,
    SEL_BYTE = 2'd3
  } regSel_e;

  typedef struct packed {
    logic       load;
    logic [2:0] lenX;
    logic [2:0] lenY;
    logic [3:0] startX;
    logic [3:0] startY;
    logic       useX;
    logic       useY;
    logic       wideX;
    logic       xToOffset;
    logic       yToOffset;
    regSel_e    raSel;
    regSel_e    rbSel;
    regSel_e    rdSel;
  } strobe_t;
endpackage

// File: rtl/argdec_field.sv
module argdec_field #(
  parameter int WIN_BYTES = 12,
  parameter int XLEN      = 64,
  parameter int MAX_LEN   = 4
) (
  input  logic [8*WIN_BYTES-1:0] win,
  input  logic [3:0]             start,
  input  logic [2:0]             len,
  output logic [XLEN-1:0]        value
);
  localparam int RAW_W = 8 * MAX_LEN;

  logic [RAW_W-1:0] raw;
  logic [XLEN-1:0]  rawWide;
  logic             signBit;

  // little-endian gather of up to MAX_LEN bytes
  always_comb begin
    raw = '0;
    for (int i = 0; i < MAX_LEN; i++) begin
      if (i < int'(len) && (int'(start) + i) < WIN_BYTES)
        raw[8*i +: 8] = win[8*(int'(start) + i) +: 8];
    end
  end

  assign rawWide = XLEN'(raw);

  // sign extension from the top bit of the last byte taken
  always_comb begin
    value   = '0;
    signBit = 1'b0;
    if (len != 3'd0) begin
      signBit = rawWide[8*int'(len)-1];
      for (int b = 0; b < XLEN; b++)
        value[b] = (b < 8*int'(len)) ? rawWide[b] : signBit;
    end
  end
endmodule

// File: rtl/argdec_ctrl.sv
module argdec_ctrl
  import argdec_pkg::*;
#(
  parameter int SKIP_W = 8
) (
  input  logic              inValid,
  input  logic [3:0]        category,
  input  logic [SKIP_W-1:0] skipLen,
  input  logic [2:0]        lenCodeA,
  input  logic [2:0]        lenCodeB,
  input  logic [2:0]        lenCodeC,
  output strobe_t           strobe
);
  localparam int AW = SKIP_W + 2;

  logic [AW-1:0] skipW;
  assign skipW = AW'(skipLen);

  function automatic logic [2:0] capLen(input logic [AW-1:0] v);
    return (v > AW'(MAX_FIELD)) ? 3'(MAX_FIELD) : v[2:0];
  endfunction

  function automatic logic [2:0] restLen(input logic [AW-1:0] total,
                                         input logic [AW-1:0] lead);
    return (total > lead) ? capLen(total - lead) : 3'd0;
  endfunction

  always_comb begin
    strobe      = '0;
    strobe.load = inValid;
    case (category)
      CAT_IMM, CAT_JUMP: begin
        strobe.lenX      = capLen(skipW);
        strobe.startX    = 4'd0;
        strobe.useX      = 1'b1;
        strobe.xToOffset = (category == CAT_JUMP);
      end
      CAT_REG_WIDE: begin
        strobe.raSel = SEL_LO;
        strobe.useX  = 1'b1;
        strobe.wideX = 1'b1;
      end
      CAT_IMM2: begin
        strobe.lenX   = capLen(AW'(lenCodeA));
        strobe.startX = 4'd1;
        strobe.lenY   = restLen(skipW, AW'(strobe.lenX) + AW'(1));
        strobe.startY = 4'd1 + 4'(strobe.lenX);
        strobe.useX   = 1'b1;
        strobe.useY   = 1'b1;
      end
      CAT_REG_IMM2, CAT_REG_IMM_JUMP: begin
        strobe.raSel     = SEL_LO;
        strobe.lenX      = capLen(AW'(lenCodeB));
        strobe.startX    = 4'd1;
        strobe.lenY      = restLen(skipW, AW'(strobe.lenX) + AW'(1));
        strobe.startY    = 4'd1 + 4'(strobe.lenX);
        strobe.useX      = 1'b1;
        strobe.useY      = 1'b1;
        strobe.yToOffset = (category == CAT_REG_IMM_JUMP);
      end
      CAT_REG_IMM, CAT_REG2_IMM, CAT_REG2_JUMP: begin
        strobe.raSel     = SEL_LO;
        strobe.rbSel     = (category == CAT_REG_IMM) ? SEL_ZERO : SEL_HI;
        strobe.lenX      = restLen(skipW, AW'(1));
        strobe.startX    = 4'd1;
        strobe.useX      = 1'b1;
        strobe.xToOffset = (category == CAT_REG2_JUMP);
      end
      CAT_REG2: begin
        strobe.rdSel = SEL_LO;
        strobe.raSel = SEL_HI;
      end
      CAT_REG2_IMM2: begin
        strobe.raSel  = SEL_LO;
        strobe.rbSel  = SEL_HI;
        strobe.lenX   = capLen(AW'(lenCodeC));
        strobe.startX = 4'd2;
        strobe.lenY   = restLen(skipW, AW'(strobe.lenX) + AW'(2));
        strobe.startY = 4'd2 + 4'(strobe.lenX);
        strobe.useX   = 1'b1;
        strobe.useY   = 1'b1;
      end
      CAT_REG3: begin
        strobe.raSel = SEL_LO;
        strobe.rbSel = SEL_HI;
        strobe.rdSel = SEL_BYTE;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/argdec_datapath.sv
module argdec_datapath
  import argdec_pkg::*;
#(
  parameter int WIN_BYTES = 12,
  parameter int XLEN      = 64,
  parameter int AVAIL_W   = 4,
  parameter int REG_W     = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  strobe_t                strobe,
  input  logic [XLEN-1:0]        pc,
  input  logic [8*WIN_BYTES-1:0] window,
  input  logic [AVAIL_W-1:0]     availBytes,
  output logic [2:0]             lenCodeA,
  output logic [2:0]             lenCodeB,
  output logic [2:0]             lenCodeC,
  output logic                   outValid,
  output logic [REG_W-1:0]       ra,
  output logic [REG_W-1:0]       rb,
  output logic [REG_W-1:0]       rd,
  output logic [XLEN-1:0]        immX,
  output logic [XLEN-1:0]        immY,
  output logic [XLEN-1:0]        offset
);
  localparam int WIN_W   = 8 * WIN_BYTES;
  localparam int WIDE_LO = 8;

  logic [WIN_W-1:0] winMasked;
  logic [7:0]       byte0, byte1;

  // bytes beyond the code image read as zero
  for (genvar k = 0; k < WIN_BYTES; k++) begin : g_mask
    assign winMasked[8*k +: 8] = (AVAIL_W'(k) < availBytes) ? window[8*k +: 8] : 8'h00;
  end

  assign byte0    = winMasked[7:0];
  assign byte1    = winMasked[15:8];
  assign lenCodeA = byte0[2:0];
  assign lenCodeB = byte0[6:4];
  assign lenCodeC = byte1[2:0];

  logic [3:0]      fStart [2];
  logic [2:0]      fLen   [2];
  logic [XLEN-1:0] fVal   [2];

  assign fStart[0] = strobe.startX;
  assign fStart[1] = strobe.startY;
  assign fLen[0]   = strobe.lenX;
  assign fLen[1]   = strobe.lenY;

  for (genvar g = 0; g < 2; g++) begin : g_field
    argdec_field #(.WIN_BYTES(WIN_BYTES), .XLEN(XLEN), .MAX_LEN(MAX_FIELD)) u_field (
      .win  (winMasked),
      .start(fStart[g]),
      .len  (fLen[g]),
      .value(fVal[g])
    );
  end

  function automatic logic [REG_W-1:0] clampReg(input logic [7:0] v);
    return (v > 8'(REG_TOP)) ? REG_W'(REG_TOP) : v[REG_W-1:0];
  endfunction

  function automatic logic [REG_W-1:0] pickReg(input regSel_e sel, input logic [7:0] b0,
                                               input logic [7:0] b1);
    case (sel)
      SEL_LO:   return clampReg({4'h0, b0[3:0]});
      SEL_HI:   return clampReg({4'h0, b0[7:4]});
      SEL_BYTE: return clampReg(b1);
      default:  return '0;
    endcase
  endfunction

  logic [REG_W-1:0] raNext, rbNext, rdNext;
  logic [XLEN-1:0]  immXNext, immYNext, offsetNext;

  always_comb begin
    raNext     = pickReg(strobe.raSel, byte0, byte1);
    rbNext     = pickReg(strobe.rbSel, byte0, byte1);
    rdNext     = pickReg(strobe.rdSel, byte0, byte1);
    immXNext   = '0;
    immYNext   = '0;
    offsetNext = '0;
    if (strobe.useX && !strobe.xToOffset)
      immXNext = strobe.wideX ? winMasked[WIDE_LO +: XLEN] : fVal[0];
    if (strobe.useY && !strobe.yToOffset)
      immYNext = fVal[1];
    if (strobe.xToOffset)
      offsetNext = pc + fVal[0];
    else if (strobe.yToOffset)
      offsetNext = pc + fVal[1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      ra       <= '0;
      rb       <= '0;
      rd       <= '0;
      immX     <= '0;
      immY     <= '0;
      offset   <= '0;
    end else begin
      outValid <= strobe.load;
      if (strobe.load) begin
        ra     <= raNext;
        rb     <= rbNext;
        rd     <= rdNext;
        immX   <= immXNext;
        immY   <= immYNext;
        offset <= offsetNext;
      end
    end
  end

  // control must never ask for a field longer than the cap
  assert_len_cap_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |-> (strobe.lenX <= 3'(MAX_FIELD) && strobe.lenY <= 3'(MAX_FIELD)));

  // second field must begin right where the first one ends
  assert_ystart_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && strobe.useY) |-> (strobe.startY == strobe.startX + 4'(strobe.lenX)));

  assert_reg_clamp_R4: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (ra <= REG_W'(REG_TOP) && rb <= REG_W'(REG_TOP) && rd <= REG_W'(REG_TOP)));

  assert_hold_R1: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobe.load) |-> (!outValid && $stable(immX) && $stable(immY) && $stable(offset)));

  // no category fills both the second immediate and the branch target
  assert_unused_zero_R13: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (immY == '0 || offset == '0));
endmodule

// File: rtl/arg_decoder.sv
module arg_decoder
  import argdec_pkg::*;
#(
  parameter int SKIP_W    = 8,
  parameter int XLEN      = 64,
  parameter int WIN_BYTES = 12,
  parameter int AVAIL_W   = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   inValid,
  input  logic [3:0]             category,
  input  logic [SKIP_W-1:0]      skipLen,
  input  logic [XLEN-1:0]        pc,
  input  logic [8*WIN_BYTES-1:0] window,
  input  logic [AVAIL_W-1:0]     availBytes,
  output logic                   outValid,
  output logic [3:0]             ra,
  output logic [3:0]             rb,
  output logic [3:0]             rd,
  output logic [XLEN-1:0]        immX,
  output logic [XLEN-1:0]        immY,
  output logic [XLEN-1:0]        offset
);
  strobe_t    strobe;
  logic [2:0] lenCodeA, lenCodeB, lenCodeC;

  argdec_ctrl #(.SKIP_W(SKIP_W)) u_ctrl (
    .inValid (inValid),
    .category(category),
    .skipLen (skipLen),
    .lenCodeA(lenCodeA),
    .lenCodeB(lenCodeB),
    .lenCodeC(lenCodeC),
    .strobe  (strobe)
  );

  argdec_datapath #(.WIN_BYTES(WIN_BYTES), .XLEN(XLEN), .AVAIL_W(AVAIL_W), .REG_W(4)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .pc        (pc),
    .window    (window),
    .availBytes(availBytes),
    .lenCodeA  (lenCodeA),
    .lenCodeB  (lenCodeB),
    .lenCodeC  (lenCodeC),
    .outValid  (outValid),
    .ra        (ra),
    .rb        (rb),
    .rd        (rd),
    .immX      (immX),
    .immY      (immY),
    .offset    (offset)
  );
endmodule

// File: tb/sim_arg_decoder.sv
`timescale 1ns/1ps
module sim_arg_decoder;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [3:0]  category = '0;
  logic [7:0]  skipLen = '0;
  logic [63:0] pc = '0;
  logic [95:0] window = '0;
  logic [3:0]  availBytes = '0;
  logic        outValid;
  logic [3:0]  ra, rb, rd;
  logic [63:0] immX, immY, offset;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  arg_decoder u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .category(category), .skipLen(skipLen),
    .pc(pc), .window(window), .availBytes(availBytes), .outValid(outValid),
    .ra(ra), .rb(rb), .rd(rd), .immX(immX), .immY(immY), .offset(offset)
  );

  typedef struct packed {
    logic [3:0]  cat;
    logic [7:0]  skip;
    logic [63:0] pcv;
    logic [95:0] win;
    logic [3:0]  avail;
    logic [3:0]  ra;
    logic [3:0]  rb;
    logic [3:0]  rd;
    logic [63:0] ix;
    logic [63:0] iy;
    logic [63:0] off;
    logic [7:0]  req;
  } vec_t;

  localparam int NVEC = 20;
  localparam vec_t TABLE [NVEC] = '{
    // R7 R3: two bytes, negative
    '{4'd1, 8'd2, 64'h1000, 96'h8234, 4'd12, 4'd0, 4'd0, 4'd0, 64'hFFFF_FFFF_FFFF_8234, 64'h0, 64'h0, 8'd7},
    // R7: length capped at four, fifth byte ignored
    '{4'd1, 8'd7, 64'h1000, 96'h0000_0000_0000_00FF_1234_5678, 4'd12, 4'd0, 4'd0, 4'd0, 64'h1234_5678, 64'h0, 64'h0, 8'd7},
    // R7: jump target wraps below zero
    '{4'd4, 8'd1, 64'h5, 96'hF0, 4'd12, 4'd0, 4'd0, 4'd0, 64'h0, 64'h0, 64'hFFFF_FFFF_FFFF_FFF5, 8'd7},
    // R8 R4: wide unsigned constant, ra 14 clamps to 12
    '{4'd2, 8'd9, 64'h1000, 96'h0000_0088_0706_0504_0302_013E, 4'd12, 4'd12, 4'd0, 4'd0, 64'h8807_0605_0403_0201, 64'h0, 64'h0, 8'd8},
    // R9: lx=3 (three-byte negative), ly=2
    '{4'd3, 8'd6, 64'h1000, 96'h0000_0000_0000_007F_8322_110B, 4'd12, 4'd0, 4'd0, 4'd0, 64'hFFFF_FFFF_FF83_2211, 64'h7F, 64'h0, 8'd9},
    // R9: lx code 7 clamps to 4, ly zero
    '{4'd3, 8'd2, 64'h1000, 96'h0000_0000_0000_00FF_FFFF_FF07, 4'd12, 4'd0, 4'd0, 4'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'h0, 8'd9},
    // R10: lx from bits 6:4
    '{4'd6, 8'd5, 64'h1000, 96'h0000_0000_0000_0012_3480_0025, 4'd12, 4'd5, 4'd0, 4'd0, 64'hFFFF_FFFF_FFFF_8000, 64'h1234, 64'h0, 8'd10},
    // R2 R10: only three bytes available
    '{4'd7, 8'd3, 64'h2000, 96'h0000_0000_0000_0004_0302_01D1, 4'd3, 4'd1, 4'd0, 4'd0, 64'h201, 64'h0, 64'h2000, 8'd2},
    // R10: second field becomes backward target
    '{4'd7, 8'd4, 64'h100, 96'h0000_0000_0000_0000_FFFE_0513, 4'd12, 4'd3, 4'd0, 4'd0, 64'h5, 64'h0, 64'hFE, 8'd10},
    // R5 R4: rd low nibble, ra high nibble clamped
    '{4'd8, 8'd1, 64'h1000, 96'hF4, 4'd12, 4'd12, 4'd0, 4'd4, 64'h0, 64'h0, 64'h0, 8'd5},
    // R12: skip-1 capped at four
    '{4'd9, 8'd8, 64'h1000, 96'h0000_0000_0000_EE11_2233_449A, 4'd12, 4'd10, 4'd9, 4'd0, 64'h1122_3344, 64'h0, 64'h0, 8'd12},
    // R12: skip of one gives zero-length offset
    '{4'd10, 8'd1, 64'hABC, 96'h8021, 4'd12, 4'd1, 4'd2, 4'd0, 64'h0, 64'h0, 64'hABC, 8'd12},
    // R11: lx=1 from byte 1, ly=3
    '{4'd11, 8'd6, 64'h1000, 96'h0000_0000_0000_0302_0180_09C7, 4'd12, 4'd7, 4'd12, 4'd0, 64'hFFFF_FFFF_FFFF_FF80, 64'h0003_0201, 64'h0, 8'd11},
    // R6: rd from whole byte 1, 0x20 clamps to 12
    '{4'd12, 8'd2, 64'h1000, 96'h205E, 4'd12, 4'd12, 4'd5, 4'd12, 64'h0, 64'h0, 64'h0, 8'd6},
    // R13: unused category gives all zero
    '{4'd13, 8'd4, 64'h1000, 96'hFFFF_FFFF, 4'd12, 4'd0, 4'd0, 4'd0, 64'h0, 64'h0, 64'h0, 8'd13},
    // R3: zero-length field
    '{4'd1, 8'd0, 64'h1000, 96'hFF, 4'd12, 4'd0, 4'd0, 4'd0, 64'h0, 64'h0, 64'h0, 8'd3},
    // R2: masked sign byte
    '{4'd1, 8'd3, 64'h1000, 96'h80_0000, 4'd2, 4'd0, 4'd0, 4'd0, 64'h0, 64'h0, 64'h0, 8'd2},
    // R12 R3: three-byte positive
    '{4'd5, 8'd4, 64'h1000, 96'h7FFF_FF0C, 4'd12, 4'd12, 4'd0, 4'd0, 64'h7F_FFFF, 64'h0, 64'h0, 8'd12},
    // R12: skip of one, no immediate
    '{4'd5, 8'd1, 64'h1000, 96'hFF_FF03, 4'd12, 4'd3, 4'd0, 4'd0, 64'h0, 64'h0, 64'h0, 8'd12},
    // R3: four-byte negative
    '{4'd1, 8'd4, 64'h1000, 96'h8000_0000, 4'd12, 4'd0, 4'd0, 4'd0, 64'hFFFF_FFFF_8000_0000, 64'h0, 64'h0, 8'd3}
  };

  task automatic check(input string what, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic checkAll(input string req, input vec_t v);
    check("outValid", req, 64'(outValid), 64'd1);
    check("ra", req, 64'(ra), 64'(v.ra));
    check("rb", req, 64'(rb), 64'(v.rb));
    check("rd", req, 64'(rd), 64'(v.rd));
    check("immX", req, immX, v.ix);
    check("immY", req, immY, v.iy);
    check("offset", req, offset, v.off);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL R1 watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] heldX;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("outValid@reset", "R1", 64'(outValid), 64'd0);
    check("immX@reset", "R1", immX, 64'd0);
    check("offset@reset", "R1", offset, 64'd0);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      vec_t v;
      v = TABLE[i];
      category   = v.cat;
      skipLen    = v.skip;
      pc         = v.pcv;
      window     = v.win;
      availBytes = v.avail;
      inValid    = 1'b1;
      @(negedge clk);
      checkAll($sformatf("R%0d", v.req), v);
    end

    // R1: hold without strobe, and single-cycle valid
    inValid    = 1'b0;
    category   = 4'd1;
    skipLen    = 8'd4;
    window     = 96'h1234_5678;
    availBytes = 4'd12;
    heldX      = immX;
    @(negedge clk);
    check("outValid drops", "R1", 64'(outValid), 64'd0);
    check("immX held", "R1", immX, heldX);
    @(negedge clk);
    check("immX still held", "R1", immX, heldX);

    // R1: one-cycle latency after the strobe
    inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check("immX after strobe", "R1", immX, 64'h1234_5678);
    check("outValid pulse", "R1", 64'(outValid), 64'd1);
    @(negedge clk);
    check("outValid single", "R1", 64'(outValid), 64'd0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule